// File: doc/BRIEF.md
# Bit-Serial Signed Power Multiplier

This block turns a pair of downsampled readings, one voltage and one current, into a single power sample for the statistics that follow it. Both operands are 16-bit two's complement fixed-point values with one integer bit and fourteen fractional bits. The result is a 32-bit two's complement word with three integer bits and twenty-eight fractional bits. That format holds every possible product exactly, including minus one times minus one, so nothing overflows and no low bits are dropped.

In power mode the product is built one multiplier bit per clock. Each cycle a partial product is formed from the next current bit and added into a single running sum. The weight of the current operand's sign bit is negative, so the partial product for that bit is subtracted on the last step. A full product takes sixteen clocks, which fits easily inside the 1024-clock spacing of new samples. In voltage mode there is no multiply. The voltage is placed in the product format by sign extension, and the result is ready one clock after the start strobe.

A one-clock done strobe marks each new result. The result register holds its value until the next operation completes.

Top module: `serial_power_mul`

## Requirements
- R1: While reset is high and on the first cycle after it, `result_o` is zero and `done_o` is low.
- R2: With `pwr_mode_i` = 1 at the start strobe, the result equals the full signed 32-bit product of `volt_i` and `curr_i`, read as 16-bit two's complement integers.
- R3: The product is correct for every sign combination, including either operand at the most negative value 0x8000. For example, 0x8000 times 0x8000 gives 0x40000000.
- R4: In power mode, `done_o` is first seen high exactly 16 rising edges after the edge that samples `start_i`.
- R5: In voltage mode (`pwr_mode_i` = 0 at the start strobe), the result bits are placed as follows. Bits 28..14 take `volt_i[14:0]`. Bits 31..29 each copy `volt_i[15]`. Bits 13..0 are zero.
- R6: In voltage mode, `done_o` is high on the first rising edge after the edge that samples `start_i`.
- R7: `done_o` is high for exactly one clock per completed operation.
- R8: `result_o` changes only on the edge that also raises `done_o`, and otherwise keeps its value.
- R9: The mode, `volt_i` and `curr_i` are captured on the start edge. Changes to them during the operation have no effect on its result.
- R10: A `start_i` pulse while an operation is in progress is ignored. It neither restarts the operation nor produces an extra done strobe.
- R11: A start strobe issued in the same cycle that `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock strobe that captures the operands and the mode |
| pwr_mode_i | input | 1 | 1 selects the product, 0 selects the sign-extended voltage |
| volt_i | input | 16 | Voltage operand, signed, 1 integer bit and 14 fractional bits |
| curr_i | input | 16 | Current operand, signed, 1 integer bit and 14 fractional bits |
| result_o | output | 32 | Signed result, 3 integer bits and 28 fractional bits |
| done_o | output | 1 | One-clock strobe marking a new result |

## Verification
The hardest situation to reach from the ports is a start strobe or an input change arriving in the middle of the sixteen-step multiply. From the outside it looks like a normal request, yet it must leave the product untouched. The bench covers this in two ways. It raises a second start with new operands and the opposite mode partway through a running product, then watches that no early or extra done strobe appears. Separately, it swaps the mode and operands one cycle after the start and checks the finished result against the operands captured at the start. The sign-bit subtraction on the final step is reached with operand pairs at 0x8000 and 0x7FFF in every sign combination.

// File: rtl/pwrmul_pkg.sv
package pwrmul_pkg;

  localparam int PM_DATA_W = 16;
  localparam int PM_FRAC_W = 14;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_BYP  = 2'd2
  } pm_state_e;

endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import pwrmul_pkg::*;
#(
  parameter int STEPS = PM_DATA_W
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic pwr_mode_i,
  output logic load_o,
  output logic run_o,
  output logic last_o,
  output logic byp_o
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

  pm_state_e       state;
  logic [CW-1:0]   cnt;

  always_comb begin
    load_o = start_i && (state == ST_IDLE);
    run_o  = (state == ST_RUN);
    last_o = run_o && (cnt == LAST_IDX);
    byp_o  = (state == ST_BYP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start_i) state <= pwr_mode_i ? ST_RUN : ST_BYP;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= ST_IDLE;
        end
        ST_BYP:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  run_end_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (state == ST_IDLE));

  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_o && !last_o) |=> run_o);

endmodule

// File: rtl/spm_datapath.sv
module spm_datapath #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14,
  parameter int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              run_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] volt_i,
  input  logic [DATA_W-1:0] curr_i,
  output logic [PROD_W-1:0] prod_o,
  output logic [PROD_W-1:0] bypass_o
);

  localparam int EXT_W = PROD_W - DATA_W;

  logic [PROD_W-1:0] mcand;
  logic [DATA_W-1:0] mplier;
  logic [PROD_W-1:0] acc;
  logic [PROD_W-1:0] pp;

  // one partial product per multiplier bit; the sign bit weighs negative
  always_comb begin
    pp       = mplier[0] ? mcand : '0;
    prod_o   = last_i ? (acc - pp) : (acc + pp);
    bypass_o = mcand << FRAC_W;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
    end else if (load_i) begin
      mcand  <= {{EXT_W{volt_i[DATA_W-1]}}, volt_i};
      mplier <= curr_i;
      acc    <= '0;
    end else if (run_i) begin
      acc    <= prod_o;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

endmodule

// File: rtl/serial_power_mul.sv
module serial_power_mul
  import pwrmul_pkg::*;
#(
  parameter int DATA_W = PM_DATA_W,
  parameter int FRAC_W = PM_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  pwr_mode_i,
  input  logic [DATA_W-1:0]     volt_i,
  input  logic [DATA_W-1:0]     curr_i,
  output logic [2*DATA_W-1:0]   result_o,
  output logic                  done_o
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int SGN_LO = DATA_W + FRAC_W - 1;

  logic              load, run, last, byp;
  logic [PROD_W-1:0] prod, bypass;

  spm_ctrl #(.STEPS(DATA_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .pwr_mode_i (pwr_mode_i),
    .load_o     (load),
    .run_o      (run),
    .last_o     (last),
    .byp_o      (byp)
  );

  spm_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .PROD_W(PROD_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .run_i    (run),
    .last_i   (last),
    .volt_i   (volt_i),
    .curr_i   (curr_i),
    .prod_o   (prod),
    .bypass_o (bypass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last || byp;
      if (last)     result_o <= prod;
      else if (byp) result_o <= bypass;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  // R5
  byp_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(byp)) |-> (result_o[FRAC_W-1:0] == '0));

  // R5
  byp_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(byp)) |->
      ($countones(result_o[PROD_W-1:SGN_LO]) == 0 ||
       $countones(result_o[PROD_W-1:SGN_LO]) == PROD_W - SGN_LO));

endmodule

// File: tb/serial_power_mul_tb.sv
module serial_power_mul_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] volt = '0;
  logic [15:0] curr = '0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  serial_power_mul dut_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .pwr_mode_i (mode),
    .volt_i     (volt),
    .curr_i     (curr),
    .result_o   (result),
    .done_o     (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_prod(input logic [15:0] v, input logic [15:0] i);
    logic signed [31:0] a, b;
    a = {{16{v[15]}}, v};
    b = {{16{i[15]}}, i};
    return a * b;
  endfunction

  function automatic logic [31:0] exp_volt(input logic [15:0] v);
    logic signed [31:0] a;
    a = {{16{v[15]}}, v};
    return a <<< 14;
  endfunction

  // called 1 time unit after a rising edge; returns at the same phase with done seen
  task automatic run_op(input logic m, input logic [15:0] v, input logic [15:0] i,
                        output int lat);
    lat = 0;
    mode = m; volt = v; curr = i; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      lat++;
      if (done) break;
    end
  endtask

  task automatic hold_check(input logic [31:0] exp, input string tag);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(!done, {tag, " R7 done low after pulse"}, {31'b0, done}, 32'h0);
      chk(result === exp, {tag, " R8 result held"}, result, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(result === 32'h0, "R1 result in reset", result, 32'h0);
    chk(done === 1'b0, "R1 done in reset", {31'b0, done}, 32'h0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(result === 32'h0 && done === 1'b0, "R1 first cycle after reset", result, 32'h0);
  endtask

  task automatic t_power(input logic [15:0] v, input logic [15:0] i, input string tag);
    int lat;
    logic [31:0] e;
    e = exp_prod(v, i);
    run_op(1'b1, v, i, lat);
    chk(lat == 16, {tag, " R4 power latency"}, lat, 16);
    chk(result === e, {tag, " R2 R3 product"}, result, e);
    hold_check(e, tag);
  endtask

  task automatic t_voltage(input logic [15:0] v, input logic [15:0] i, input string tag);
    int lat;
    logic [31:0] e;
    e = exp_volt(v);
    run_op(1'b0, v, i, lat);
    chk(lat == 1, {tag, " R6 voltage latency"}, lat, 1);
    chk(result === e, {tag, " R5 sign-extended voltage"}, result, e);
    hold_check(e, tag);
  endtask

  task automatic t_capture();
    int lat;
    logic [31:0] e;
    e = exp_prod(16'h3000, 16'hD000);
    mode = 1'b1; volt = 16'h3000; curr = 16'hD000; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; mode = 1'b0; volt = 16'h1111; curr = 16'h7777;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      lat++;
      if (done) break;
    end
    chk(lat == 16, "R9 mode kept from start", lat, 16);
    chk(result === e, "R9 operands captured at start", result, e);
    hold_check(e, "R9");
  endtask

  task automatic t_busy_start();
    int lat;
    int extra;
    logic [31:0] e;
    e = exp_prod(16'h5A5A, 16'h8001);
    mode = 1'b1; volt = 16'h5A5A; curr = 16'h8001; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      lat++;
      if (lat == 5) begin
        mode = 1'b0; volt = 16'h0123; curr = 16'h4567; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    chk(lat == 16, "R10 no restart from busy start", lat, 16);
    chk(result === e, "R10 result of first operation", result, e);
    extra = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (done) extra++;
    end
    chk(extra == 0, "R10 no extra done strobe", extra, 0);
    chk(result === e, "R10 result unchanged afterwards", result, e);
  endtask

  task automatic t_back_to_back();
    int lat;
    logic [31:0] e1, e2;
    e1 = exp_prod(16'h7FFF, 16'h7FFF);
    e2 = exp_volt(16'hC001);
    run_op(1'b1, 16'h7FFF, 16'h7FFF, lat);
    chk(result === e1 && lat == 16, "R11 first of pair", result, e1);
    run_op(1'b0, 16'hC001, 16'h0000, lat);
    chk(lat == 1, "R11 start accepted in done cycle", lat, 1);
    chk(result === e2, "R11 second result", result, e2);
    run_op(1'b1, 16'hFFFF, 16'h8000, lat);
    chk(lat == 16, "R11 third start in done cycle", lat, 16);
    chk(result === exp_prod(16'hFFFF, 16'h8000), "R11 third result", result,
        exp_prod(16'hFFFF, 16'h8000));
    hold_check(exp_prod(16'hFFFF, 16'h8000), "R11");
  endtask

  initial begin
    t_reset();
    @(posedge clk); #1;
    t_power(16'h2000, 16'h4000, "pos*pos");
    t_power(16'hE000, 16'h4000, "neg*pos");
    t_power(16'h2000, 16'hC000, "pos*neg");
    t_power(16'hE000, 16'hC000, "neg*neg");
    t_power(16'h8000, 16'h8000, "min*min");
    t_power(16'h8000, 16'h7FFF, "min*max");
    t_power(16'h7FFF, 16'h8000, "max*min");
    t_power(16'h1234, 16'h0000, "x*zero");
    t_power(16'hABCD, 16'hFFFF, "x*minus_lsb");
    t_voltage(16'h7FFF, 16'h1234, "vmax");
    t_voltage(16'h8000, 16'h1234, "vmin");
    t_voltage(16'hA5C3, 16'h0000, "vneg");
    t_voltage(16'h0001, 16'hFFFF, "vlsb");
    t_capture();
    t_busy_start();
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule